// File: doc/BRIEF.md
# Block Floating Point Scaling Unit

This unit sits at the output of one radix-4 transform pass. It keeps 16 of the 19 bits of each butterfly result. The bits it keeps depend on the word-growth mode. It also tracks which sample in the block is largest, measured as the smallest count of redundant sign bits seen in either component during the pass. When the pass ends, that count becomes a left shift. The shift normalises every word read back for the next pass, so that the largest value fills the 16-bit word again.

The unit keeps a running total of the shifts applied over the transform and presents it as a 4-bit scale tag. In the narrow (2-bit) growth selection, a result whose dropped top bit differs from the next bit is an overflow. An overflow latches tag code 15 and forces every later word of the transform to zero. A disable input turns the normalisation off.

A pass is framed by a start strobe. A flag sampled with that strobe marks the first pass of a new transform. An end strobe follows the last result of the pass.

Top module: `bfp_scaler`

## Requirements
- R1: In a pass opened with `pass_first`=1, the kept word is bits [17:2] of each 19-bit result, whatever `grow3` holds. It appears on `sel_re`/`sel_im` one cycle after `res_valid`.
- R2: In a pass opened with `pass_first`=0, the kept word is bits [17:2] when `grow3`=0 and bits [18:3] when `grow3`=1.
- R3: Overflow is a valid result, in a pass using the [17:2] selection, whose bit 18 differs from bit 17 in either component. From the next cycle, `scale_tag` reads 15 and holds until a first pass starts. The word kept for that result is output as zero.
- R4: After an overflow, every later `sel_re`/`sel_im` and `nrm_re`/`nrm_im` word is zero until a first pass starts.
- R5: A sample's sign-bit count is the number of bits below bit 15 that equal bit 15, taken as the smaller of the real and imaginary counts. On `pass_end` the step is the smallest of: the least count seen during the pass, 4, and the shifts still allowed. The step appears on `pass_shift` one cycle later and holds until the next `pass_end` or first-pass start.
- R6: `scale_tag` is the sum of the steps applied since the first pass started. The sum is capped at 14 when `grow3`=0 at `pass_end`, and at 15 when `grow3`=1.
- R7: `nrm_re`/`nrm_im` equal `ld_re`/`ld_im` shifted left by the current `pass_shift`, one cycle after `ld_valid`.
- R8: With `bfp_off`=1 at `pass_end`, the step is 0 and `scale_tag` does not change.
- R9: `pass_start` with `pass_first`=1 clears `scale_tag`, `pass_shift` and the overflow state on the next cycle.
- R10: While `rst` is held, `scale_tag`, `pass_shift`, `sel_valid` and `nrm_valid` are 0.
- R11: `sel_valid` follows `res_valid` and `nrm_valid` follows `ld_valid`, each with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pass_start | input | 1 | Strobe opening a pass |
| pass_first | input | 1 | Sampled with pass_start: 1 marks the first pass of a transform |
| pass_end | input | 1 | Strobe closing a pass; commits the step |
| grow3 | input | 1 | Later-pass growth mode: 0 keeps [17:2], 1 keeps [18:3] |
| bfp_off | input | 1 | 1 forces a zero step at pass_end |
| res_valid | input | 1 | Butterfly result present |
| res_re | input | 19 | Result, real part |
| res_im | input | 19 | Result, imaginary part |
| sel_valid | output | 1 | Kept word valid |
| sel_re | output | 16 | Kept word, real part |
| sel_im | output | 16 | Kept word, imaginary part |
| ld_valid | input | 1 | Stored word read back for the next pass |
| ld_re | input | 16 | Read-back word, real part |
| ld_im | input | 16 | Read-back word, imaginary part |
| nrm_valid | output | 1 | Normalised word valid |
| nrm_re | output | 16 | Normalised word, real part |
| nrm_im | output | 16 | Normalised word, imaginary part |
| pass_shift | output | 3 | Left shift in force for read-back words |
| scale_tag | output | 4 | Cumulative shift count; 15 also flags overflow |

## Verification
The properties assume three things about the inputs:
- `pass_start` and `pass_end` never share a cycle with each other or with `res_valid`.
- Results arrive only between a start and an end strobe.
- No overflow result coincides with a first-pass start.

The stimulus drives each strobe alone, on its own negative clock edge, and releases it one cycle later. Results and read-back words are presented strictly inside a pass. Under these conditions the step never exceeds the sign-bit headroom of the words it shifts.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int BFP_IN_W = 19;
  localparam int BFP_W    = 16;
  localparam int BFP_STEP = 4;
  localparam int BFP_TAG  = 4;

  typedef enum logic {GROW_NARROW = 1'b0, GROW_WIDE = 1'b1} grow_e;
endpackage

// File: rtl/bfp_select.sv
module bfp_select #(
  parameter int IN_W = 19,
  parameter int W    = 16
) (
  input  logic                   first,
  input  logic                   use3,
  input  logic [1:0][IN_W-1:0]   res,
  output logic [1:0][W-1:0]      kept,
  output logic                   ovf_hit
);
  localparam int TOP = IN_W - 1;
  logic       use_wide;
  logic [1:0] lane_ovf;

  assign use_wide = !first && use3;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    assign kept[k]     = use_wide ? res[k][TOP -: W] : res[k][TOP-1 -: W];
    assign lane_ovf[k] = res[k][TOP] ^ res[k][TOP-1];
  end

  assign ovf_hit = !use_wide && (|lane_ovf);
endmodule

// File: rtl/bfp_peak.sv
module bfp_peak #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 valid,
  input  logic [1:0][W-1:0]    word,
  output logic [CNT_W-1:0]     peak_now
);
  function automatic logic [CNT_W-1:0] sign_run(input logic [W-1:0] w);
    logic run;
    sign_run = '0;
    run      = 1'b1;
    for (int i = W - 2; i >= 0; i--) begin
      if (run && (w[i] == w[W-1])) sign_run = sign_run + 1'b1;
      else run = 1'b0;
    end
  endfunction

  logic [CNT_W-1:0] pk_q, c_re, c_im, c_min;

  assign c_re     = sign_run(word[0]);
  assign c_im     = sign_run(word[1]);
  assign c_min    = (c_re < c_im) ? c_re : c_im;
  assign peak_now = (valid && (c_min < pk_q)) ? c_min : pk_q;

  always_ff @(posedge clk) begin
    if (rst || clr) pk_q <= CNT_W'(W - 1);
    else            pk_q <= peak_now;
  end
endmodule

// File: rtl/bfp_shift_ctl.sv
module bfp_shift_ctl #(
  parameter int CNT_W  = 4,
  parameter int STEP   = 4,
  parameter int TAG_W  = 4,
  parameter int STEP_W = $clog2(STEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              pass_end,
  input  logic              off,
  input  logic              use3,
  input  logic [CNT_W-1:0]  peak,
  input  logic              ovf_set,
  output logic [STEP_W-1:0] step_q,
  output logic [TAG_W-1:0]  total_q,
  output logic              ovf_q
);
  localparam logic [TAG_W-1:0] CAP_WIDE   = {TAG_W{1'b1}};
  localparam logic [TAG_W-1:0] CAP_NARROW = CAP_WIDE - 1'b1;

  logic [TAG_W-1:0] cap, room, lim;

  always_comb begin
    cap  = use3 ? CAP_WIDE : CAP_NARROW;
    room = (total_q < cap) ? (cap - total_q) : '0;
    lim  = (TAG_W'(peak) < TAG_W'(STEP)) ? TAG_W'(peak) : TAG_W'(STEP);
    if (lim > room) lim = room;
    if (off)        lim = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      step_q  <= '0;
      total_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (ovf_set) ovf_q <= 1'b1;
      if (pass_end) begin
        step_q  <= STEP_W'(lim);
        total_q <= total_q + lim;
      end
    end
  end
endmodule

// File: rtl/bfp_norm.sv
module bfp_norm #(
  parameter int W      = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0][W-1:0] in_word,
  input  logic [STEP_W-1:0] shift,
  input  logic              kill,
  output logic              out_valid,
  output logic [1:0][W-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  for (genvar k = 0; k < 2; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)       out_word[k] <= '0;
      else if (kill) out_word[k] <= '0;
      else           out_word[k] <= in_word[k] << shift;
    end
  end
endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler
  import bfp_pkg::*;
#(
  parameter int IN_W  = BFP_IN_W,
  parameter int W     = BFP_W,
  parameter int STEP  = BFP_STEP,
  parameter int TAG_W = BFP_TAG
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pass_start,
  input  logic                          pass_first,
  input  logic                          pass_end,
  input  logic                          grow3,
  input  logic                          bfp_off,
  input  logic                          res_valid,
  input  logic [IN_W-1:0]               res_re,
  input  logic [IN_W-1:0]               res_im,
  output logic                          sel_valid,
  output logic [W-1:0]                  sel_re,
  output logic [W-1:0]                  sel_im,
  input  logic                          ld_valid,
  input  logic [W-1:0]                  ld_re,
  input  logic [W-1:0]                  ld_im,
  output logic                          nrm_valid,
  output logic [W-1:0]                  nrm_re,
  output logic [W-1:0]                  nrm_im,
  output logic [$clog2(STEP+1)-1:0]     pass_shift,
  output logic [TAG_W-1:0]              scale_tag
);
  localparam int CNT_W  = $clog2(W);
  localparam int STEP_W = $clog2(STEP + 1);

  grow_e               mode;
  logic                in_first_q;
  logic                restart, ovf_hit, ovf_now, ovf_q;
  logic [1:0][IN_W-1:0] res_pair;
  logic [1:0][W-1:0]   kept, sel_q, ld_pair, nrm_pair;
  logic [CNT_W-1:0]    peak_now;
  logic [STEP_W-1:0]   step_q;
  logic [TAG_W-1:0]    total_q;

  assign mode     = grow_e'(grow3);
  assign restart  = pass_start && pass_first;
  assign res_pair = {res_im, res_re};
  assign ld_pair  = {ld_im, ld_re};

  always_ff @(posedge clk) begin
    if (rst)             in_first_q <= 1'b1;
    else if (pass_start) in_first_q <= pass_first;
  end

  bfp_select #(.IN_W(IN_W), .W(W)) u_select (
    .first   (in_first_q),
    .use3    (mode == GROW_WIDE),
    .res     (res_pair),
    .kept    (kept),
    .ovf_hit (ovf_hit)
  );

  assign ovf_now = res_valid && ovf_hit;

  bfp_peak #(.W(W), .CNT_W(CNT_W)) u_peak (
    .clk      (clk),
    .rst      (rst),
    .clr      (pass_start),
    .valid    (res_valid),
    .word     (kept),
    .peak_now (peak_now)
  );

  bfp_shift_ctl #(.CNT_W(CNT_W), .STEP(STEP), .TAG_W(TAG_W), .STEP_W(STEP_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .pass_end (pass_end),
    .off      (bfp_off),
    .use3     (mode == GROW_WIDE),
    .peak     (peak_now),
    .ovf_set  (ovf_now),
    .step_q   (step_q),
    .total_q  (total_q),
    .ovf_q    (ovf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_q     <= '0;
    end else begin
      sel_valid <= res_valid;
      sel_q     <= (ovf_q || ovf_now) ? '0 : kept;
    end
  end

  bfp_norm #(.W(W), .STEP_W(STEP_W)) u_norm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ld_valid),
    .in_word   (ld_pair),
    .shift     (step_q),
    .kill      (ovf_q),
    .out_valid (nrm_valid),
    .out_word  (nrm_pair)
  );

  assign sel_re     = sel_q[0];
  assign sel_im     = sel_q[1];
  assign nrm_re     = nrm_pair[0];
  assign nrm_im     = nrm_pair[1];
  assign pass_shift = step_q;
  assign scale_tag  = ovf_q ? {TAG_W{1'b1}} : total_q;
endmodule

// File: rtl/bfp_scaler_chk.sv
module bfp_scaler_chk #(
  parameter int W      = 16,
  parameter int STEP   = 4,
  parameter int TAG_W  = 4,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              pass_start,
  input logic              pass_first,
  input logic              pass_end,
  input logic              bfp_off,
  input logic              res_valid,
  input logic              ld_valid,
  input logic              sel_valid,
  input logic [W-1:0]      sel_re,
  input logic [W-1:0]      sel_im,
  input logic              nrm_valid,
  input logic [W-1:0]      nrm_re,
  input logic [W-1:0]      nrm_im,
  input logic [STEP_W-1:0] pass_shift,
  input logic [TAG_W-1:0]  scale_tag,
  input logic              ovf_q
);
  localparam logic [TAG_W-1:0] TAG_OVF = {TAG_W{1'b1}};

  assert_shift_cap_R5: assert property (@(posedge clk) disable iff (rst)
    pass_shift <= STEP_W'(STEP));

  assert_shift_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!pass_end && !(pass_start && pass_first)) |=> $stable(pass_shift));

  assert_tag_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (scale_tag == TAG_OVF && !(pass_start && pass_first)) |=> scale_tag == TAG_OVF);

  assert_tag_grows_R6: assert property (@(posedge clk) disable iff (rst)
    !(pass_start && pass_first) |=> scale_tag >= $past(scale_tag));

  assert_sel_kill_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && sel_valid) |-> (sel_re == '0 && sel_im == '0));

  assert_nrm_kill_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && $past(ovf_q) && nrm_valid) |-> (nrm_re == '0 && nrm_im == '0));

  assert_off_step_R8: assert property (@(posedge clk) disable iff (rst)
    (pass_end && bfp_off) |=> pass_shift == '0);

  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (pass_start && pass_first) |=> (scale_tag == '0 && pass_shift == '0));

  assert_sel_valid_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> sel_valid);

  assert_nrm_valid_R11: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> nrm_valid);
endmodule

bind bfp_scaler bfp_scaler_chk #(
  .W(W), .STEP(STEP), .TAG_W(TAG_W), .STEP_W(STEP_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pass_start (pass_start),
  .pass_first (pass_first),
  .pass_end   (pass_end),
  .bfp_off    (bfp_off),
  .res_valid  (res_valid),
  .ld_valid   (ld_valid),
  .sel_valid  (sel_valid),
  .sel_re     (sel_re),
  .sel_im     (sel_im),
  .nrm_valid  (nrm_valid),
  .nrm_re     (nrm_re),
  .nrm_im     (nrm_im),
  .pass_shift (pass_shift),
  .scale_tag  (scale_tag),
  .ovf_q      (ovf_q)
);

// File: tb/bfp_scaler_bench.sv
`timescale 1ns/1ps
module bfp_scaler_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pass_start = 0, pass_first = 0, pass_end = 0;
  logic        grow3 = 0, bfp_off = 0;
  logic        res_valid = 0, ld_valid = 0;
  logic [18:0] res_re = '0, res_im = '0;
  logic [15:0] ld_re = '0, ld_im = '0;
  logic        sel_valid, nrm_valid;
  logic [15:0] sel_re, sel_im, nrm_re, nrm_im;
  logic [2:0]  pass_shift;
  logic [3:0]  scale_tag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  bfp_scaler u_bfp_scaler (
    .clk(clk), .rst(rst), .pass_start(pass_start), .pass_first(pass_first),
    .pass_end(pass_end), .grow3(grow3), .bfp_off(bfp_off),
    .res_valid(res_valid), .res_re(res_re), .res_im(res_im),
    .sel_valid(sel_valid), .sel_re(sel_re), .sel_im(sel_im),
    .ld_valid(ld_valid), .ld_re(ld_re), .ld_im(ld_im),
    .nrm_valid(nrm_valid), .nrm_re(nrm_re), .nrm_im(nrm_im),
    .pass_shift(pass_shift), .scale_tag(scale_tag)
  );

  // fields: first, grow3, res_re, res_im, expected re, expected im
  localparam logic [71:0] VEC [0:5] = '{
    {1'b1, 1'b1, 19'h1ABCD, 19'h62468, 16'h6AF3, 16'h891A},
    {1'b0, 1'b0, 19'h1ABCD, 19'h62468, 16'h6AF3, 16'h891A},
    {1'b0, 1'b1, 19'h1ABCD, 19'h62468, 16'h3579, 16'hC48D},
    {1'b0, 1'b1, 19'h62468, 19'h1ABCD, 16'hC48D, 16'h3579},
    {1'b1, 1'b0, 19'h00004, 19'h7FFFF, 16'h0001, 16'hFFFF},
    {1'b0, 1'b1, 19'h40000, 19'h3FFFF, 16'h8000, 16'h7FFF}
  };

  function automatic logic [18:0] mk2(input logic [15:0] w);
    return {w[15], w, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic start_pass(input logic first);
    pass_start = 1'b1; pass_first = first;
    @(negedge clk);
    pass_start = 1'b0; pass_first = 1'b0;
  endtask

  task automatic end_pass();
    pass_end = 1'b1;
    @(negedge clk);
    pass_end = 1'b0;
  endtask

  task automatic push(input logic [18:0] re, input logic [18:0] im);
    res_valid = 1'b1; res_re = re; res_im = im;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic load(input logic [15:0] re, input logic [15:0] im);
    ld_valid = 1'b1; ld_re = re; ld_im = im;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 tag", 32'(scale_tag), 0);
    chk("R10 shift", 32'(pass_shift), 0);
    chk("R10 valids", {30'd0, sel_valid, nrm_valid}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R11: selection table
    for (int i = 0; i < 6; i++) begin
      grow3 = VEC[i][70];
      start_pass(VEC[i][71]);
      push(VEC[i][69:51], VEC[i][50:32]);
      chk("R1/R2 sel_re", 32'(sel_re), 32'(VEC[i][31:16]));
      chk("R1/R2 sel_im", 32'(sel_im), 32'(VEC[i][15:0]));
      chk("R11 sel_valid", 32'(sel_valid), 1);
    end
    chk("R2 wide no overflow", 32'(scale_tag), 0);

    // R5: step capped at 4, min over re/im and over the block
    grow3 = 1'b0;
    start_pass(1'b1);
    push(mk2(16'h0100), mk2(16'h0040));
    end_pass();
    chk("R5 step cap", 32'(pass_shift), 4);
    chk("R6 tag", 32'(scale_tag), 4);

    start_pass(1'b0);
    load(16'h0123, 16'hFFF0);                 // R7
    chk("R7 nrm_re", 32'(nrm_re), 32'h1230);
    chk("R7 nrm_im", 32'(nrm_im), 32'hFF00);
    chk("R11 nrm_valid", 32'(nrm_valid), 1);
    push(mk2(16'h0C00), mk2(16'hFF00));
    end_pass();
    chk("R5 min re/im", 32'(pass_shift), 3);
    chk("R6 tag sum", 32'(scale_tag), 7);

    start_pass(1'b0);
    push(mk2(16'h2000), 19'h0);
    push(mk2(16'h0010), mk2(16'h0010));
    end_pass();
    chk("R5 block min", 32'(pass_shift), 1);
    chk("R6 tag sum", 32'(scale_tag), 8);

    // R6: caps
    start_pass(1'b0); push(19'h0, 19'h0); end_pass();
    chk("R6 tag 12", 32'(scale_tag), 12);
    start_pass(1'b0); push(19'h0, 19'h0); end_pass();
    chk("R6 room step", 32'(pass_shift), 2);
    chk("R6 narrow cap", 32'(scale_tag), 14);
    start_pass(1'b0); push(19'h0, 19'h0); end_pass();
    chk("R6 at cap", 32'(pass_shift), 0);
    chk("R6 hold 14", 32'(scale_tag), 14);
    grow3 = 1'b1;
    start_pass(1'b0); push(19'h0, 19'h0); end_pass();
    chk("R6 wide cap step", 32'(pass_shift), 1);
    chk("R6 wide cap", 32'(scale_tag), 15);

    // R9 and R8
    grow3 = 1'b0;
    start_pass(1'b1);
    chk("R9 tag clear", 32'(scale_tag), 0);
    chk("R9 shift clear", 32'(pass_shift), 0);
    push(19'h0, 19'h0);
    bfp_off = 1'b1;
    end_pass();
    bfp_off = 1'b0;
    chk("R8 off step", 32'(pass_shift), 0);
    chk("R8 off tag", 32'(scale_tag), 0);

    // R3 R4: overflow
    start_pass(1'b1);
    push(mk2(16'h0100), 19'h0);
    end_pass();
    start_pass(1'b0);
    push(19'h20000, 19'h0);
    chk("R3 ovf word zero", 32'(sel_re), 0);
    chk("R3 ovf tag", 32'(scale_tag), 15);
    push(mk2(16'h1234), mk2(16'h0042));
    chk("R4 sel zeroed", {sel_re, sel_im}, 0);
    load(16'h0011, 16'h0001);
    chk("R4 nrm zeroed", {nrm_re, nrm_im}, 0);
    end_pass();
    chk("R3 tag held", 32'(scale_tag), 15);
    start_pass(1'b1);
    chk("R9 ovf cleared", 32'(scale_tag), 0);
    push(mk2(16'h1234), 19'h0);
    chk("R9 sel restored", 32'(sel_re), 32'h1234);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule